// File: doc/BRIEF.md
# Timer Clock Prescaler with Cross-Domain Clear Handshake

This block divides a timer's source clock by a selectable power of two and emits a one-cycle count-enable tick. A 10-bit free-running counter forms the divider. A 3-bit select chooses the ratio, or stops the tick. The prescaler runs in one of two domains. In synchronous mode it runs on the bus clock and ticks on `tick_io`. In asynchronous mode it runs on a separate crystal clock and ticks on `tick_xt`. The mode input decides which of the two counters is live and which is held in reset.

Software can restart the divider by writing 1 to a self-clearing clear-request bit. In synchronous mode the clear takes effect on the next bus edge, and the bit never reads back as 1. In asynchronous mode the request flips a toggle that is synchronized into the crystal domain. That domain clears its counter and flips an acknowledge toggle, which is synchronized back to the bus domain. The bit reads 1 until the acknowledge arrives. The mode and the select are meant to be changed only while the prescaler is quiet.

Top module: `tmr_prescaler`

## Requirements
- R1: `clk_sel` encodes the division ratio as follows: 000 off, 001 = 1, 010 = 8, 011 = 32, 100 = 64, 101 = 128, 110 = 256, 111 = 1024. The live tick output pulses for one cycle of its domain clock once every ratio cycles. With ratio 1 it stays high every cycle.
- R2: With `clk_sel` = 000, neither tick output pulses.
- R3: In synchronous mode (`async_mode` = 0), after a clear applied at bus edge E0, `tick_io` is high after edge Ek exactly when k is a multiple of the ratio.
- R4: In synchronous mode, a one-cycle `rst_wr` with `rst_wdata` = 1 clears the divider at that bus edge, and `rst_rd` stays 0.
- R5: A write with `rst_wdata` = 0 has no effect. The tick phase continues and `rst_rd` is unchanged.
- R6: In asynchronous mode, ticks appear only on `tick_xt`, spaced by the ratio in crystal cycles, and `tick_io` stays 0. In synchronous mode, `tick_xt` stays 0.
- R7: In asynchronous mode, a write of 1 makes `rst_rd` read 1 from the next bus edge. `rst_rd` returns to 0 only after the crystal-domain clear has happened and its acknowledge has crossed back, which takes between 3 and 30 bus cycles at the bench clock ratio.
- R8: After an asynchronous clear, the next `tick_xt` comes one full ratio of crystal cycles after the clearing crystal edge.
- R9: A write of 1 while `rst_rd` reads 1 is ignored. It starts no second request, and `rst_rd` stays 0 once the first request completes.
- R10: While `rst` is high, and after it is released, `rst_rd`, `tick_io` and `tick_xt` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus (I/O) clock |
| rst | input | 1 | Synchronous active-high reset, bus domain; resynchronized for the crystal domain |
| xtal_clk | input | 1 | Crystal clock used in asynchronous mode |
| async_mode | input | 1 | 0: run on `clk`; 1: run on `xtal_clk` |
| clk_sel | input | 3 | Division ratio select (see R1) |
| rst_wr | input | 1 | One-cycle write strobe for the clear-request bit |
| rst_wdata | input | 1 | Value written with `rst_wr`; only 1 acts |
| rst_rd | output | 1 | Read-back of the clear-request bit |
| tick_io | output | 1 | Count-enable tick, bus domain |
| tick_xt | output | 1 | Count-enable tick, crystal domain |

## Verification
Several internal faults show at the ports:
- A wrong divider mask or counter width gives a tick spacing that differs from the ratio, so the first or second tick period of every ratio sweep exposes it.
- A clear that does not reach the counter leaves the tick phase unrelated to the write. The synchronous sweep measures the phase from the clearing edge, and the asynchronous test measures the distance from the acknowledge to the next tick, so it is caught within one period.
- A broken toggle or acknowledge path either never drops `rst_rd`, which the bounded wait catches, or re-raises it, which the quiet window after a repeated write catches.

// File: rtl/presc_pkg.sv
`timescale 1ns/1ps
package presc_pkg;
  localparam int PRESC_W = 10;

  typedef enum logic [2:0] {
    CS_OFF, CS_D1, CS_D8, CS_D32, CS_D64, CS_D128, CS_D256, CS_D1024
  } cs_e;

  // log2 of the division ratio for each select code
  function automatic int div_shift(input cs_e sel);
    case (sel)
      CS_D8:    return 3;
      CS_D32:   return 5;
      CS_D64:   return 6;
      CS_D128:  return 7;
      CS_D256:  return 8;
      CS_D1024: return 10;
      default:  return 0;
    endcase
  endfunction
endpackage

// File: rtl/presc_sync2.sv
`timescale 1ns/1ps
module presc_sync2 #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/presc_core.sv
`timescale 1ns/1ps
module presc_core
  import presc_pkg::*;
#(
  parameter int PS_W = PRESC_W
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic clr,
  input  cs_e  sel,
  output logic tick
);
  logic [PS_W-1:0] cnt;
  logic [PS_W:0]   full;
  logic [PS_W-1:0] mask;

  // low-bit mask: ratio-1
  always_comb begin
    full = ({{PS_W{1'b0}}, 1'b1} << div_shift(sel)) - 1'b1;
    mask = full[PS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst || !en || clr) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= (sel != CS_OFF) && ((cnt & mask) == mask);
    end
  end
endmodule

// File: rtl/presc_rst_hs.sv
`timescale 1ns/1ps
module presc_rst_hs #(
  parameter int SYNC_STAGES = 2
) (
  input  logic bus_clk,
  input  logic bus_rst,
  input  logic xt_clk,
  input  logic xt_rst,
  input  logic req_set,
  output logic pend,
  output logic xt_clr
);
  // bus side: request toggle, pending flag from toggle mismatch
  logic req_t, req_n, ack_s;
  assign req_n = req_t ^ (req_set & ~pend);

  always_ff @(posedge bus_clk) begin
    if (bus_rst) begin
      req_t <= 1'b0;
      pend  <= 1'b0;
    end else begin
      req_t <= req_n;
      pend  <= req_n ^ ack_s;
    end
  end

  // crystal side: detect toggle edge, clear, echo acknowledge
  logic req_s, req_d, ack_t;

  presc_sync2 #(.W(1), .STAGES(SYNC_STAGES)) u_req_sync (
    .clk(xt_clk), .rst(xt_rst), .d(req_t), .q(req_s));

  assign xt_clr = req_s ^ req_d;

  always_ff @(posedge xt_clk) begin
    if (xt_rst) begin
      req_d <= 1'b0;
      ack_t <= 1'b0;
    end else begin
      req_d <= req_s;
      if (xt_clr) ack_t <= req_s;
    end
  end

  presc_sync2 #(.W(1), .STAGES(SYNC_STAGES)) u_ack_sync (
    .clk(bus_clk), .rst(bus_rst), .d(ack_t), .q(ack_s));
endmodule

// File: rtl/tmr_prescaler.sv
`timescale 1ns/1ps
module tmr_prescaler
  import presc_pkg::*;
#(
  parameter int PS_W        = PRESC_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       xtal_clk,
  input  logic       async_mode,
  input  logic [2:0] clk_sel,
  input  logic       rst_wr,
  input  logic       rst_wdata,
  output logic       rst_rd,
  output logic       tick_io,
  output logic       tick_xt
);
  logic wr_one;
  logic xt_rst, xt_async, xt_clr;

  assign wr_one = rst_wr & rst_wdata;

  // crystal-domain reset and mode
  presc_sync2 #(.W(1), .STAGES(SYNC_STAGES)) u_xrst_sync (
    .clk(xtal_clk), .rst(1'b0), .d(rst), .q(xt_rst));

  presc_sync2 #(.W(1), .STAGES(SYNC_STAGES)) u_mode_sync (
    .clk(xtal_clk), .rst(xt_rst), .d(async_mode), .q(xt_async));

  presc_rst_hs #(.SYNC_STAGES(SYNC_STAGES)) u_hs (
    .bus_clk (clk),
    .bus_rst (rst),
    .xt_clk  (xtal_clk),
    .xt_rst  (xt_rst),
    .req_set (wr_one & async_mode),
    .pend    (rst_rd),
    .xt_clr  (xt_clr)
  );

  presc_core #(.PS_W(PS_W)) u_core_io (
    .clk(clk), .rst(rst), .en(~async_mode), .clr(wr_one & ~async_mode),
    .sel(cs_e'(clk_sel)), .tick(tick_io));

  presc_core #(.PS_W(PS_W)) u_core_xt (
    .clk(xtal_clk), .rst(xt_rst), .en(xt_async), .clr(xt_clr),
    .sel(cs_e'(clk_sel)), .tick(tick_xt));
endmodule

// File: rtl/tmr_prescaler_chk.sv
`timescale 1ns/1ps
module tmr_prescaler_chk (
  input logic       clk,
  input logic       rst,
  input logic       xtal_clk,
  input logic       async_mode,
  input logic [2:0] clk_sel,
  input logic       rst_wr,
  input logic       rst_wdata,
  input logic       rst_rd,
  input logic       tick_io,
  input logic       tick_xt
);
  p_rd_rise_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_rd) |-> $past(async_mode && rst_wr && rst_wdata));

  p_rd_quiet_sync_r4: assert property (@(posedge clk) disable iff (rst)
    (!async_mode && !rst_rd) |=> !rst_rd);

  p_clear_sync_r4: assert property (@(posedge clk) disable iff (rst)
    (!async_mode && rst_wr && rst_wdata) |=> !tick_io);

  p_stop_io_r2: assert property (@(posedge clk) disable iff (rst)
    (clk_sel == 3'b000) |=> !tick_io);

  p_stop_xt_r2: assert property (@(posedge xtal_clk) disable iff (rst)
    ($past(clk_sel) == 3'b000) |-> !tick_xt);

  p_mode_io_r6: assert property (@(posedge clk) disable iff (rst)
    async_mode |=> !tick_io);

  p_div1_r1: assert property (@(posedge clk) disable iff (rst)
    (!async_mode && clk_sel == 3'b001 && !(rst_wr && rst_wdata)) |=> tick_io);
endmodule

bind tmr_prescaler tmr_prescaler_chk u_chk (.*);

// File: tb/tmr_prescaler_tb_top.sv
`timescale 1ns/1ps
module tmr_prescaler_tb_top;
  logic clk = 1'b0, xtal_clk = 1'b0;
  logic rst = 1'b1, async_mode = 1'b0, rst_wr = 1'b0, rst_wdata = 1'b0;
  logic [2:0] clk_sel = 3'd0;
  logic rst_rd, tick_io, tick_xt;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  int dv[8] = '{0, 1, 8, 32, 64, 128, 256, 1024};

  always #10 clk = ~clk;       // 50 MHz bus clock
  always #31 xtal_clk = ~xtal_clk;

  tmr_prescaler dut_i (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic pulse_wr(input logic v);
    @(negedge clk); rst_wr = 1'b1; rst_wdata = v;
    @(negedge clk); rst_wr = 1'b0; rst_wdata = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "watchdog", 0, 1);
    report();
  end

  initial begin
    int n, errs, d;
    repeat (20) @(negedge clk);
    check(rst_rd == 0 && tick_io == 0 && tick_xt == 0, "R10 in reset", int'(rst_rd), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check(rst_rd == 0 && tick_io == 0 && tick_xt == 0, "R10 after reset", int'(tick_io), 0);

    // R2 synchronous, select off
    n = 0;
    repeat (300) begin @(negedge clk); n += int'(tick_io); end
    check(n == 0, "R2 sync off ticks", n, 0);

    // R1/R3/R4/R5/R6 synchronous sweep
    for (int s = 1; s < 8; s++) begin
      d = dv[s];
      clk_sel = 3'(s);
      pulse_wr(1'b1);                       // clear at edge E0
      errs = 0;
      for (int k = 1; k <= 3 * d + 2; k++) begin
        if (s == 2 && k == 3) begin rst_wr = 1'b1; rst_wdata = 1'b0; end // R5 write 0
        if (s == 2 && k == 4) rst_wr = 1'b0;
        @(negedge clk);
        if (tick_io != ((k % d) == 0) || rst_rd != 1'b0 || tick_xt != 1'b0) errs++;
      end
      check(errs == 0, (s == 2) ? "R5 R3 R4 R6 sync phase" : "R1 R3 R4 R6 sync phase", errs, 0);
    end

    // asynchronous mode
    async_mode = 1'b1;
    clk_sel = 3'd0;
    repeat (20) @(negedge clk);
    n = 0;
    repeat (300) begin @(negedge xtal_clk); n += int'(tick_xt) + int'(tick_io); end
    check(n == 0, "R2 async off ticks", n, 0);

    for (int s = 1; s < 8; s++) begin
      d = dv[s];
      clk_sel = 3'(s);
      repeat (2) do @(negedge xtal_clk); while (!tick_xt);
      n = 0;
      errs = 0;
      do begin @(negedge xtal_clk); n++; if (tick_io) errs++; end while (!tick_xt);
      check(n == d && errs == 0, "R1 R6 async interval", n, d);
    end

    // R7/R8: clear far from the natural tick phase
    clk_sel = 3'd7;
    do @(negedge xtal_clk); while (!tick_xt);
    repeat (500) @(negedge xtal_clk);
    pulse_wr(1'b1);
    check(rst_rd == 1, "R7 pending set", int'(rst_rd), 1);
    n = 1;
    while (rst_rd && n < 200) begin @(negedge clk); n++; end
    check(n >= 3 && n <= 30, "R7 pending duration", n, 10);
    n = 0;
    do begin @(negedge xtal_clk); n++; end while (!tick_xt && n < 2000);
    check(n >= 1016 && n <= 1025, "R8 tick after async clear", n, 1023);

    // R9: repeated write while pending is ignored
    clk_sel = 3'd3;
    pulse_wr(1'b1);
    check(rst_rd == 1, "R9 pending set", int'(rst_rd), 1);
    pulse_wr(1'b1);
    n = 0;
    while (rst_rd && n < 200) begin @(negedge clk); n++; end
    check(n < 30, "R9 pending completes", n, 5);
    errs = 0;
    repeat (40) begin @(negedge clk); errs += int'(rst_rd); end
    check(errs == 0, "R9 no second request", errs, 0);

    // R5 in async mode: write 0 does not raise the bit
    pulse_wr(1'b0);
    check(rst_rd == 0, "R5 async write 0", int'(rst_rd), 0);

    // R4 back in synchronous mode: write 1 never reads back
    async_mode = 1'b0;
    repeat (5) @(negedge clk);
    pulse_wr(1'b1);
    check(rst_rd == 0, "R4 sync readback", int'(rst_rd), 0);

    report();
  end
endmodule